// File: doc/BRIEF.md
# Double-Column Drain Hit Buffer

This block is the periphery readout of one double column in a pixel readout chip. The column has a set of double-pixel cells, and each cell holds at most one pending hit. A fast wired-OR tells the periphery, in the same bunch crossing, that a free cell has just been hit. The periphery then stores the current crossing time stamp in a small time-stamp queue and latches the hit flags and amplitudes into the cells, tagged with the queue slot of that crossing.

A drain engine then walks the latched pixels of the oldest undrained crossing, one pixel per clock and from the lowest address upward. It copies each pixel's address and amplitude into a data queue. The first data entry of every crossing carries an event-start marker. When no tagged pixel is left, the drain closes that crossing. The time-stamp entry then becomes readable, and it carries the number of data entries written for the crossing and a flag that shows whether any of its hits were discarded.

A readout agent pops one time stamp and then the data entries of that crossing. Hit losses caused by a full time-stamp queue and by a full data queue are counted separately. Each loss counter is saturating and can be read at any time.

Top module: `dcol_hit_buffer`

## Requirements
- R1: `fast_or_o` is high, in the same cycle, exactly when `hit_i` sets at least one pixel of a cell that has no pending hit. A hit on a cell that still has a pending pixel is not stored, and on its own it neither raises `fast_or_o` nor creates an event.
- R2: On each cycle where `fast_or_o` is high and the time-stamp queue can accept, `ts_i` is stored. Entries are read out in arrival order. With the column otherwise idle, an event with k hits becomes readable (`ts_rdy_o`) exactly k+1 clock edges after the edge that stored it.
- R3: The time-stamp queue holds 12 entries. A hit crossing that arrives while it is full, with no pop in that cycle, is dropped entirely. Its newly hit pixels are added to `ts_lost_o`.
- R4: The pixel address is 2*cell + side, which gives 0..159. The hits of one event come out in strictly ascending address order, one per clock.
- R5: Each data entry carries the amplitude that `amp_i[8*addr +: 8]` had in the storing crossing. `data_mark_o` is 1 on the first entry of an event and 0 on every other entry.
- R6: The data queue holds 32 entries. Once a hit of an event finds it full, that hit and all later hits of the event are discarded and each one is added to `data_lost_o`. The event's `ts_ovf_o` reads 1.
- R7: `ts_nhit_o` equals the number of data entries written for that event.
- R8: A pop and a push in the same cycle are both accepted when a queue is full, on either queue, and no loss is counted.
- R9: `ts_lost_o` and `data_lost_o` are 16-bit counters that stop at 65535.
- R10: After reset both queues are empty, both counters are 0 and `fast_or_o` is low when no hit is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 160 | New-hit strobe per pixel for this crossing |
| amp_i | input | 1280 | Amplitude per pixel, 8 bits each, pixel p at [8p+7:8p] |
| ts_i | input | 8 | Current crossing time stamp |
| fast_or_o | output | 1 | Column holds a new hit in this crossing |
| ts_pop_i | input | 1 | Pop the head time-stamp entry |
| ts_rdy_o | output | 1 | Head time-stamp entry is fully drained and readable |
| ts_head_o | output | 8 | Time stamp of the head entry |
| ts_ovf_o | output | 1 | Head event lost hits to a full data queue |
| ts_nhit_o | output | 8 | Data entries stored for the head event |
| data_pop_i | input | 1 | Pop the head data entry |
| data_rdy_o | output | 1 | Data queue not empty |
| data_mark_o | output | 1 | Head data entry starts an event |
| data_addr_o | output | 8 | Pixel address of the head data entry |
| data_amp_o | output | 8 | Amplitude of the head data entry |
| ts_lost_o | output | 16 | Hits lost to a full time-stamp queue |
| data_lost_o | output | 16 | Hits lost to a full data queue |

## Verification
A wrong cell tag or a stale latch shows up at the data port. A pixel either appears under the wrong time stamp or shows up a second time. Because the bench drains every event completely before it checks the next one, such a fault becomes visible within one event's worth of pops. A priority-search fault breaks the ascending address order on the first event that has two or more hits. A miscounting occupancy register shows up as an early or late `ts_rdy_o`, a loss counted while a pop was taking place, or an entry that is missing when the bench reads the queue back after filling it.

// File: rtl/dcol_pkg.sv
`timescale 1ns/1ps
package dcol_pkg;
  // What the drain engine does in the current cycle
  typedef enum logic [1:0] {
    DR_IDLE,
    DR_WRITE,
    DR_DROP,
    DR_CLOSE
  } drain_act_e;
endpackage

// File: rtl/dcol_cells.sv
`timescale 1ns/1ps
module dcol_cells #(
  parameter int N_CELLS = 80,
  parameter int ADC_W   = 8,
  parameter int TAG_W   = 4,
  localparam int NPIX   = 2 * N_CELLS,
  localparam int IDX_W  = $clog2(NPIX),
  localparam int PC_W   = $clog2(NPIX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPIX-1:0]       hit_i,
  input  logic [NPIX*ADC_W-1:0] amp_i,
  input  logic                  accept_i,
  input  logic [TAG_W-1:0]      tag_i,
  input  logic                  clr_i,
  input  logic [IDX_W-1:0]      clr_idx_i,
  input  logic [TAG_W-1:0]      srch_tag_i,
  output logic                  fast_or_o,
  output logic [PC_W-1:0]       new_hits_o,
  output logic                  found_o,
  output logic [IDX_W-1:0]      found_idx_o,
  output logic [ADC_W-1:0]      found_amp_o
);
  logic [NPIX-1:0]    flag_q, flag_d;
  logic [TAG_W-1:0]   tag_q [N_CELLS];
  logic [ADC_W-1:0]   amp_q [NPIX];
  logic [N_CELLS-1:0] cell_free, cell_load;
  logic [NPIX-1:0]    new_bits, match;

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    assign cell_free[c]          = ~(flag_q[2*c] | flag_q[2*c+1]);
    assign new_bits[2*c +: 2]    = hit_i[2*c +: 2] & {2{cell_free[c]}};
    assign cell_load[c]          = accept_i & (|new_bits[2*c +: 2]);
    assign match[2*c +: 2]       = flag_q[2*c +: 2] & {2{tag_q[c] == srch_tag_i}};
  end

  assign fast_or_o = |new_bits;
  assign found_o   = |match;

  always_comb begin
    new_hits_o = '0;
    for (int p = 0; p < NPIX; p++) new_hits_o = new_hits_o + PC_W'(new_bits[p]);
  end

  // lowest pending pixel of the searched event wins
  always_comb begin
    found_idx_o = '0;
    for (int p = NPIX - 1; p >= 0; p--) begin
      if (match[p]) found_idx_o = IDX_W'(p);
    end
  end

  assign found_amp_o = amp_q[found_idx_o];

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d[clr_idx_i] = 1'b0;
    for (int c = 0; c < N_CELLS; c++) begin
      if (cell_load[c]) flag_d[2*c +: 2] = hit_i[2*c +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  // payload registers: load enable only, no reset
  always_ff @(posedge clk) begin
    for (int c = 0; c < N_CELLS; c++) begin
      if (cell_load[c]) begin
        tag_q[c]     <= tag_i;
        amp_q[2*c]   <= amp_i[(2*c)*ADC_W +: ADC_W];
        amp_q[2*c+1] <= amp_i[(2*c+1)*ADC_W +: ADC_W];
      end
    end
  end

  // R1
  accept_fast_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |-> fast_or_o);

  // R4
  clr_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> flag_q[clr_idx_i]);
endmodule

// File: rtl/dcol_ts_buf.sv
`timescale 1ns/1ps
module dcol_ts_buf #(
  parameter int DEPTH  = 12,
  parameter int TS_W   = 8,
  parameter int HC_W   = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic             pop_i,
  input  logic             inc_i,
  input  logic             bad_i,
  input  logic             done_i,
  output logic [PTR_W-1:0] wr_slot_o,
  output logic [PTR_W-1:0] drn_slot_o,
  output logic             pending_o,
  output logic             full_o,
  output logic             rdy_o,
  output logic [TS_W-1:0]  head_ts_o,
  output logic             head_ovf_o,
  output logic [HC_W-1:0]  head_cnt_o
);
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d, dr_q, dr_d;
  logic [OCC_W-1:0] occ_q, occ_d, und_q, und_d;
  logic [TS_W-1:0]  ts_mem  [DEPTH];
  logic             ovf_mem [DEPTH];
  logic [HC_W-1:0]  cnt_mem [DEPTH];
  logic             pop_eff;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdy_o      = (occ_q != und_q);
  assign pop_eff    = pop_i & rdy_o;
  assign full_o     = (occ_q == OCC_W'(DEPTH)) & ~pop_eff;
  assign pending_o  = (und_q != '0);
  assign wr_slot_o  = wr_q;
  assign drn_slot_o = dr_q;
  assign head_ts_o  = ts_mem[rd_q];
  assign head_ovf_o = ovf_mem[rd_q];
  assign head_cnt_o = cnt_mem[rd_q];

  always_comb begin
    wr_d  = push_i  ? bump(wr_q) : wr_q;
    rd_d  = pop_eff ? bump(rd_q) : rd_q;
    dr_d  = done_i  ? bump(dr_q) : dr_q;
    occ_d = occ_q + OCC_W'(push_i) - OCC_W'(pop_eff);
    und_d = und_q + OCC_W'(push_i) - OCC_W'(done_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0; rd_q <= '0; dr_q <= '0; occ_q <= '0; und_q <= '0;
    end else begin
      wr_q <= wr_d; rd_q <= rd_d; dr_q <= dr_d; occ_q <= occ_d; und_q <= und_d;
    end
  end

  // the push slot and the drain slot never coincide while an event is open
  always_ff @(posedge clk) begin
    if (push_i) begin
      ts_mem[wr_q]  <= ts_i;
      ovf_mem[wr_q] <= 1'b0;
      cnt_mem[wr_q] <= '0;
    end
    if (inc_i) cnt_mem[dr_q] <= cnt_mem[dr_q] + 1'b1;
    if (bad_i) ovf_mem[dr_q] <= 1'b1;
  end

  // R3
  ts_occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));

  // R2
  ts_drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    und_q <= occ_q);

  // R2
  ts_close_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> pending_o);

  // R8
  ts_push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
endmodule

// File: rtl/dcol_data_buf.sv
`timescale 1ns/1ps
module dcol_data_buf #(
  parameter int DEPTH  = 32,
  parameter int W      = 17,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic         rdy_o,
  output logic [W-1:0] dout_o
);
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     mem [DEPTH];
  logic             pop_eff;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdy_o   = (cnt_q != '0);
  assign pop_eff = pop_i & rdy_o;
  assign full_o  = (cnt_q == CNT_W'(DEPTH)) & ~pop_eff;
  assign dout_o  = mem[rd_q];

  always_comb begin
    wr_d  = push_i  ? bump(wr_q) : wr_q;
    rd_d  = pop_eff ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CNT_W'(push_i) - CNT_W'(pop_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0; rd_q <= '0; cnt_q <= '0;
    end else begin
      wr_q <= wr_d; rd_q <= rd_d; cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= din_i;
  end

  // R6
  data_push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);

  // R6
  data_occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/dcol_sat_cnt.sv
`timescale 1ns/1ps
module dcol_sat_cnt #(
  parameter int W     = 16,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;

  assign sum   = {1'b0, cnt_q} + (W+1)'(inc_i);
  assign cnt_d = sum[W] ? '1 : sum[W-1:0];
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q >= $past(cnt_q));

  // R9
  cnt_sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_q) |=> (&cnt_q));
endmodule

// File: rtl/dcol_hit_buffer.sv
`timescale 1ns/1ps
module dcol_hit_buffer
  import dcol_pkg::*;
#(
  parameter int N_CELLS    = 80,
  parameter int ADC_W      = 8,
  parameter int TS_W       = 8,
  parameter int TS_DEPTH   = 12,
  parameter int DATA_DEPTH = 32,
  parameter int CNT_W      = 16,
  localparam int NPIX      = 2 * N_CELLS,
  localparam int IDX_W     = $clog2(NPIX),
  localparam int PC_W      = $clog2(NPIX + 1),
  localparam int TAG_W     = $clog2(TS_DEPTH),
  localparam int DW        = 1 + IDX_W + ADC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPIX-1:0]       hit_i,
  input  logic [NPIX*ADC_W-1:0] amp_i,
  input  logic [TS_W-1:0]       ts_i,
  output logic                  fast_or_o,
  input  logic                  ts_pop_i,
  output logic                  ts_rdy_o,
  output logic [TS_W-1:0]       ts_head_o,
  output logic                  ts_ovf_o,
  output logic [PC_W-1:0]       ts_nhit_o,
  input  logic                  data_pop_i,
  output logic                  data_rdy_o,
  output logic                  data_mark_o,
  output logic [IDX_W-1:0]      data_addr_o,
  output logic [ADC_W-1:0]      data_amp_o,
  output logic [CNT_W-1:0]      ts_lost_o,
  output logic [CNT_W-1:0]      data_lost_o
);
  drain_act_e       act;
  logic             first_q, first_d, ovf_q, ovf_d;
  logic             ts_full, ts_pend, ts_push, d_full;
  logic [TAG_W-1:0] wr_slot, drn_slot;
  logic [PC_W-1:0]  new_hits, ts_loss_inc, d_loss_inc;
  logic             found;
  logic [IDX_W-1:0] found_idx;
  logic [ADC_W-1:0] found_amp;
  logic [DW-1:0]    d_dout;

  assign ts_push = fast_or_o & ~ts_full;

  dcol_cells #(.N_CELLS(N_CELLS), .ADC_W(ADC_W), .TAG_W(TAG_W)) u_cells (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit_i),
    .amp_i      (amp_i),
    .accept_i   (ts_push),
    .tag_i      (wr_slot),
    .clr_i      ((act == DR_WRITE) || (act == DR_DROP)),
    .clr_idx_i  (found_idx),
    .srch_tag_i (drn_slot),
    .fast_or_o  (fast_or_o),
    .new_hits_o (new_hits),
    .found_o    (found),
    .found_idx_o(found_idx),
    .found_amp_o(found_amp)
  );

  dcol_ts_buf #(.DEPTH(TS_DEPTH), .TS_W(TS_W), .HC_W(PC_W)) u_ts (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (ts_push),
    .ts_i      (ts_i),
    .pop_i     (ts_pop_i),
    .inc_i     (act == DR_WRITE),
    .bad_i     (act == DR_DROP),
    .done_i    (act == DR_CLOSE),
    .wr_slot_o (wr_slot),
    .drn_slot_o(drn_slot),
    .pending_o (ts_pend),
    .full_o    (ts_full),
    .rdy_o     (ts_rdy_o),
    .head_ts_o (ts_head_o),
    .head_ovf_o(ts_ovf_o),
    .head_cnt_o(ts_nhit_o)
  );

  dcol_data_buf #(.DEPTH(DATA_DEPTH), .W(DW)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .push_i(act == DR_WRITE),
    .din_i ({first_q, found_idx, found_amp}),
    .pop_i (data_pop_i),
    .full_o(d_full),
    .rdy_o (data_rdy_o),
    .dout_o(d_dout)
  );

  assign {data_mark_o, data_addr_o, data_amp_o} = d_dout;

  // drain decision for the oldest open event
  always_comb begin
    act = DR_IDLE;
    if (ts_pend) begin
      if (!found)              act = DR_CLOSE;
      else if (ovf_q | d_full) act = DR_DROP;
      else                     act = DR_WRITE;
    end
  end

  always_comb begin
    first_d = first_q;
    ovf_d   = ovf_q;
    case (act)
      DR_WRITE: first_d = 1'b0;
      DR_DROP:  ovf_d   = 1'b1;
      DR_CLOSE: begin first_d = 1'b1; ovf_d = 1'b0; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else begin
      first_q <= first_d;
      ovf_q   <= ovf_d;
    end
  end

  assign ts_loss_inc = (fast_or_o & ts_full) ? new_hits : '0;
  assign d_loss_inc  = PC_W'(act == DR_DROP);

  dcol_sat_cnt #(.W(CNT_W), .INC_W(PC_W)) u_ts_lost (
    .clk(clk), .rst_n(rst_n), .inc_i(ts_loss_inc), .cnt_o(ts_lost_o)
  );

  dcol_sat_cnt #(.W(CNT_W), .INC_W(PC_W)) u_data_lost (
    .clk(clk), .rst_n(rst_n), .inc_i(d_loss_inc), .cnt_o(data_lost_o)
  );

  // R6
  drop_keeps_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == DR_DROP) |=> (ovf_q || act == DR_CLOSE || !ts_pend));
endmodule

// File: tb/dcol_hit_buffer_tb.sv
`timescale 1ns/1ps
module dcol_hit_buffer_tb;
  localparam int NPIX = 160;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NPIX-1:0]   hit_i;
  logic [NPIX*8-1:0] amp_i;
  logic [7:0]        ts_i;
  logic              fast_or_o, ts_pop_i, ts_rdy_o, ts_ovf_o;
  logic [7:0]        ts_head_o, ts_nhit_o;
  logic              data_pop_i, data_rdy_o, data_mark_o;
  logic [7:0]        data_addr_o, data_amp_o;
  logic [15:0]       ts_lost_o, data_lost_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dcol_hit_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .amp_i(amp_i), .ts_i(ts_i),
    .fast_or_o(fast_or_o), .ts_pop_i(ts_pop_i), .ts_rdy_o(ts_rdy_o),
    .ts_head_o(ts_head_o), .ts_ovf_o(ts_ovf_o), .ts_nhit_o(ts_nhit_o),
    .data_pop_i(data_pop_i), .data_rdy_o(data_rdy_o), .data_mark_o(data_mark_o),
    .data_addr_o(data_addr_o), .data_amp_o(data_amp_o),
    .ts_lost_o(ts_lost_o), .data_lost_o(data_lost_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] amp_of(input int p, input int ts);
    return 8'((p * 3 + ts * 5 + 1) % 256);
  endfunction

  function automatic logic [NPIX-1:0] one_bit(input int p);
    logic [NPIX-1:0] v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  task automatic inject(input logic [NPIX-1:0] hv, input int ts, output bit fo);
    hit_i = hv;
    ts_i  = 8'(ts);
    for (int p = 0; p < NPIX; p++) amp_i[p*8 +: 8] = amp_of(p, ts);
    #1 fo = fast_or_o;
    @(posedge clk); @(negedge clk);
    hit_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!ts_rdy_o && n < 500) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
  endtask

  task automatic pop_event(input logic [NPIX-1:0] hv, input int ts, input int cnt_exp,
                           input bit ovf_exp, input int skip, input string req);
    int n;
    int j;
    wait_rdy(n);
    chk({req, " ts ready"}, ts_rdy_o, 1);
    chk({req, " R2 ts order"}, ts_head_o, ts % 256);
    chk({req, " R7 hit count"}, ts_nhit_o, cnt_exp);
    chk({req, " R6 ovf flag"}, ts_ovf_o, ovf_exp);
    ts_pop_i = 1'b1;
    @(posedge clk); @(negedge clk);
    ts_pop_i = 1'b0;
    j = 0;
    for (int p = 0; p < NPIX; p++) begin
      if (hv[p]) begin
        if (j >= skip && j < cnt_exp) begin
          chk({req, " data ready"}, data_rdy_o, 1);
          chk({req, " R5 marker"}, data_mark_o, (j == 0) ? 1 : 0);
          chk({req, " R4 address"}, data_addr_o, p);
          chk({req, " R5 amplitude"}, data_amp_o, amp_of(p, ts));
          data_pop_i = 1'b1;
          @(posedge clk); @(negedge clk);
          data_pop_i = 1'b0;
        end
        j++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run finished)");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NPIX-1:0] hv;
    bit fo;
    int n;
    rst_n = 1'b0; hit_i = '0; amp_i = '0; ts_i = '0;
    ts_pop_i = 1'b0; data_pop_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 ts empty", ts_rdy_o, 0);
    chk("R10 data empty", data_rdy_o, 0);
    chk("R10 ts_lost", ts_lost_o, 0);
    chk("R10 data_lost", data_lost_o, 0);
    chk("R10 fast_or idle", fast_or_o, 0);

    // R4 sweep of every single pixel, R2 latency k+1
    for (int p = 0; p < NPIX; p++) begin
      hv = one_bit(p);
      inject(hv, p, fo);
      chk("R1 fast_or single", fo, 1);
      wait_rdy(n);
      chk("R2 latency single", n, 2);
      pop_event(hv, p, 1, 0, 0, "R4 sweep");
    end

    // multi-hit patterns
    for (int k = 0; k < 4; k++) begin
      hv = '0;
      case (k)
        0: begin hv[3] = 1; hv[4] = 1; hv[80] = 1; hv[159] = 1; end
        1: for (int p = 0; p < NPIX; p += 10) hv[p] = 1'b1;
        2: begin hv[0] = 1; hv[1] = 1; end
        default: begin hv[158] = 1; hv[159] = 1; hv[77] = 1; end
      endcase
      inject(hv, 200 + k, fo);
      chk("R1 fast_or pattern", fo, 1);
      wait_rdy(n);
      chk("R2 latency pattern", n, $countones(hv) + 1);
      pop_event(hv, 200 + k, $countones(hv), 0, 0, "R4 pattern");
    end

    // R1 hits on cells with a pending pixel are ignored
    hv = '0;
    for (int p = 0; p < 20; p += 2) hv[p] = 1'b1;
    inject(hv, 210, fo);
    inject(one_bit(19) | one_bit(120), 211, fo);
    chk("R1 fast_or mixed", fo, 1);
    inject(one_bit(17), 212, fo);
    chk("R1 fast_or busy cell", fo, 0);
    pop_event(hv, 210, 10, 0, 0, "R1 first");
    pop_event(one_bit(120), 211, 1, 0, 0, "R1 busy ignored");
    idle(20);
    chk("R1 no event from busy hit", ts_rdy_o, 0);
    chk("R1 data empty", data_rdy_o, 0);
    chk("R1 no loss counted", ts_lost_o, 0);

    // R3 fill the time-stamp queue, then overflow
    for (int i = 0; i < 12; i++) inject(one_bit(2 * i), 50 + i, fo);
    idle(30);
    inject(one_bit(140) | one_bit(141), 99, fo);
    chk("R3 fast_or when full", fo, 1);
    chk("R3 ts_lost after drop", ts_lost_o, 2);

    // R8 push and pop in the same cycle on a full time-stamp queue
    chk("R8 head before pop", ts_head_o, 50);
    chk("R8 data head", data_addr_o, 0);
    hit_i = one_bit(150);
    ts_i = 8'd62;
    for (int p = 0; p < NPIX; p++) amp_i[p*8 +: 8] = amp_of(p, 62);
    ts_pop_i = 1'b1; data_pop_i = 1'b1;
    @(posedge clk); @(negedge clk);
    hit_i = '0; ts_pop_i = 1'b0; data_pop_i = 1'b0;
    idle(10);
    chk("R8 no ts loss on pop+push", ts_lost_o, 2);

    // R9 saturation with the queue full
    for (int i = 0; i < 420; i++) inject('1, 0, fo);
    chk("R9 ts_lost saturated", ts_lost_o, 65535);
    chk("R9 data_lost untouched", data_lost_o, 0);
    for (int i = 1; i < 12; i++) pop_event(one_bit(2 * i), 50 + i, 1, 0, 0, "R3 order");
    pop_event(one_bit(150), 62, 1, 0, 0, "R8 ts push");
    idle(5);
    chk("R3 dropped crossings absent", ts_rdy_o, 0);

    // R6 data queue overflow inside one event
    hv = '0;
    for (int p = 0; p < 40; p++) hv[p] = 1'b1;
    inject(hv, 160, fo);
    wait_rdy(n);
    chk("R6 data_lost", data_lost_o, 8);
    pop_event(hv, 160, 32, 1, 0, "R6 overflow");
    chk("R6 rest discarded", data_rdy_o, 0);

    // R8 push and pop in the same cycle on a full data queue
    hv = '0;
    for (int p = 0; p < 32; p++) hv[p] = 1'b1;
    inject(hv, 170, fo);
    wait_rdy(n);
    chk("R6 exact fill no loss", data_lost_o, 8);
    inject(one_bit(100), 171, fo);
    chk("R8 data head marker", data_mark_o, 1);
    data_pop_i = 1'b1;
    @(posedge clk); @(negedge clk);
    data_pop_i = 1'b0;
    pop_event(hv, 170, 32, 0, 1, "R8 full data");
    pop_event(one_bit(100), 171, 1, 0, 0, "R8 data push");
    chk("R8 no data loss on pop+push", data_lost_o, 8);

    idle(5);
    chk("R7 ts empty at end", ts_rdy_o, 0);
    chk("R7 data empty at end", data_rdy_o, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule